// File: doc/BRIEF.md
# Line-Addressed Recirculating Shift Memory

This block stores data in a set of independent recirculating shift-register lines, each holding a fixed number of bits. A line number and an operation code are captured on a start strobe. From then on, only the addressed line receives shift enables. Every other line stays frozen. The active line is rotated through exactly one full revolution, so access time depends on the line length and not on the total capacity.

Three operations are supported. A read presents each bit on the serial output as it leaves the line and feeds it back into the line. A write replaces each departing bit with the serial input bit. A refresh recirculates the line without producing output. A single-cycle completion pulse marks the end of every operation, and a new strobe can be accepted in that same cycle.

Top module: `line_shift_mem`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `rvalid_o` and `rdata_o` are low, and every bit of every line is 0.
- R2: A `start_i` sampled high while `busy_o` is low raises `busy_o` on the next cycle. `busy_o` then stays high for exactly LINE_BITS cycles, which is one shift of the selected line per cycle.
- R3: `done_o` is high for exactly one cycle, namely the first cycle after the last shift. `busy_o` is low in that cycle.
- R4: During a read (`op_i` = 2'b00), `rvalid_o` is high in every busy cycle. `rdata_o` carries the line's bits in stored order, one per cycle, and the line's contents are unchanged afterwards.
- R5: During a write (`op_i` = 2'b01), the `wdata_i` value sampled in busy cycle j becomes stored bit j. A later read returns the written sequence in the same order.
- R6: During a refresh (`op_i` = 2'b10), `rvalid_o` and `rdata_o` stay low and the line's contents are unchanged.
- R7: A `start_i` that arrives while `busy_o` is high is ignored. Changes on `addr_i` and `op_i` during an operation have no effect, because both are captured at the accepted strobe.
- R8: An operation on one line leaves every other line unchanged. At most one line shifts in any cycle, and no line shifts while the block is idle.
- R9: Operation code 2'b11 behaves as a refresh.
- R10: A `start_i` that is high in the cycle where `done_o` is high is accepted, giving back-to-back operations with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when idle |
| addr_i | input | $clog2(NUM_LINES) | Line number |
| op_i | input | 2 | Operation: 00 read, 01 write, 10/11 refresh |
| wdata_i | input | 1 | Serial write bit, sampled in each write busy cycle |
| rdata_o | output | 1 | Serial read bit |
| rvalid_o | output | 1 | `rdata_o` is valid (read in progress) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |

## Verification
Two events can fall in the same cycle. One is the completion pulse of an operation. The other is the acceptance of the next strobe. The bench provokes this by raising `start_i` exactly when `done_o` is observed high. It then judges, through a per-cycle reference model, that the new operation begins on the next edge with the newly captured line and code. The bench also pulses `start_i` and toggles `addr_i`/`op_i` mid-operation. It then reads back the lines those stray requests named, to show that they were left untouched.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    OP_READ    = 2'b00,
    OP_WRITE   = 2'b01,
    OP_REFRESH = 2'b10,
    OP_SPARE   = 2'b11
  } lsm_op_e;
endpackage

// File: rtl/lsm_ctrl.sv
module lsm_ctrl
  import lsm_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int LINE_BITS = 16,
  localparam int AW = $clog2(NUM_LINES),
  localparam int CW = $clog2(LINE_BITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  lsm_op_e       op_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] line_o,
  output lsm_op_e       op_o
);
  localparam logic [CW-1:0] LAST = CW'(LINE_BITS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      cnt_q  <= '0;
      line_o <= '0;
      op_o   <= OP_READ;
    end else begin
      done_o <= 1'b0;
      if (busy_o) begin
        if (cnt_q == LAST) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (start_i) begin
        // capture request; later changes on addr/op are ignored
        busy_o <= 1'b1;
        line_o <= addr_i;
        op_o   <= op_i;
      end
    end
  end
endmodule

// File: rtl/lsm_decode.sv
module lsm_decode #(
  parameter int NUM_LINES = 8,
  localparam int AW = $clog2(NUM_LINES)
) (
  input  logic                 en_i,
  input  logic [AW-1:0]        line_i,
  output logic [NUM_LINES-1:0] sel_o
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_sel
    assign sel_o[g] = en_i && (line_i == AW'(g));
  end
endmodule

// File: rtl/lsm_line.sv
module lsm_line #(
  parameter int LINE_BITS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_i,
  input  logic write_i,
  input  logic wdata_i,
  output logic tail_o
);
  logic [LINE_BITS-1:0] bits_q;
  logic                 fill;

  assign tail_o = bits_q[0];
  assign fill   = write_i ? wdata_i : bits_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bits_q <= '0;
    else if (shift_i) bits_q <= {fill, bits_q[LINE_BITS-1:1]};
  end
endmodule

// File: rtl/line_shift_mem.sv
module line_shift_mem
  import lsm_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int LINE_BITS = 16,
  localparam int AW = $clog2(NUM_LINES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    op_i,
  input  logic          wdata_i,
  output logic          rdata_o,
  output logic          rvalid_o,
  output logic          busy_o,
  output logic          done_o
);
  logic [AW-1:0]        act_line;
  lsm_op_e              act_op;
  logic [NUM_LINES-1:0] shift_sel;
  logic [NUM_LINES-1:0] tails;
  logic                 wr_act;
  logic                 rd_act;

  lsm_ctrl #(.NUM_LINES(NUM_LINES), .LINE_BITS(LINE_BITS)) i_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .addr_i (addr_i),
    .op_i   (lsm_op_e'(op_i)),
    .busy_o (busy_o),
    .done_o (done_o),
    .line_o (act_line),
    .op_o   (act_op)
  );

  lsm_decode #(.NUM_LINES(NUM_LINES)) i_dec (
    .en_i  (busy_o),
    .line_i(act_line),
    .sel_o (shift_sel)
  );

  assign wr_act = busy_o && (act_op == OP_WRITE);
  assign rd_act = busy_o && (act_op == OP_READ);

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    lsm_line #(.LINE_BITS(LINE_BITS)) i_line (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .shift_i(shift_sel[g]),
      .write_i(wr_act),
      .wdata_i(wdata_i),
      .tail_o (tails[g])
    );
  end

  assign rvalid_o = rd_act;
  assign rdata_o  = rd_act && |(tails & shift_sel);
endmodule

// File: rtl/lsm_checker.sv
module lsm_checker #(
  parameter int NUM_LINES = 8,
  parameter int LINE_BITS = 16,
  localparam int AW = $clog2(NUM_LINES)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic                 busy_i,
  input logic                 done_i,
  input logic                 rvalid_i,
  input logic [AW-1:0]        line_i,
  input logic [NUM_LINES-1:0] sel_i
);
  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= 0;
    else if (busy_i) run_q <= run_q + 1;
    else             run_q <= 0;
  end

  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_i |=> busy_i);
  assert_busy_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> run_q < LINE_BITS);
  assert_busy_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> $past(run_q) == LINE_BITS - 1);
  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);
  assert_done_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !busy_i);
  assert_fall_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> done_i);
  assert_rvalid_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_i |-> busy_i);
  assert_line_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && $past(busy_i) |-> $stable(line_i));
  assert_one_line_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_i));
  assert_idle_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i != '0) |-> busy_i);
endmodule

bind line_shift_mem lsm_checker #(.NUM_LINES(NUM_LINES), .LINE_BITS(LINE_BITS)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_i  (busy_o),
  .done_i  (done_o),
  .rvalid_i(rvalid_o),
  .line_i  (act_line),
  .sel_i   (shift_sel)
);

// File: tb/test_line_shift_mem.sv
module test_line_shift_mem;
  localparam int NL = 8;
  localparam int K  = 16;
  localparam int AW = $clog2(NL);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [1:0]    op = 2'b00;
  logic          wdata = 1'b0;
  logic          rdata, rvalid, busy, done;

  always #5 clk = ~clk;

  line_shift_mem #(.NUM_LINES(NL), .LINE_BITS(K)) i_line_shift_mem (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .op_i(op),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .busy_o(busy), .done_o(done)
  );

  // behavioural reference model
  bit     mm [NL][K];
  bit     m_busy, m_done;
  int     m_cnt, m_line;
  bit [1:0] m_op;
  logic [K-1:0] wpat = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NL; l++) for (int b = 0; b < K; b++) mm[l][b] = 1'b0;
      m_busy = 0; m_done = 0; m_cnt = 0; m_line = 0; m_op = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (m_op == 2'b01) mm[m_line][m_cnt] = wdata;
        m_cnt++;
        if (m_cnt == K) begin m_busy = 0; m_done = 1; m_cnt = 0; end
      end else if (start) begin
        m_busy = 1; m_line = int'(addr); m_op = op; m_cnt = 0;
      end
    end
  end

  int    n_vec = 0, n_bad = 0;
  string tag = "R1";

  task automatic chk(string req, logic act, logic exp, string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    logic e_rv, e_rd;
    @(negedge clk);
    e_rv = m_busy && (m_op == 2'b00);
    e_rd = e_rv ? mm[m_line][m_cnt] : 1'b0;
    chk("R2", busy, m_busy, "busy_o");
    chk("R3", done, m_done, "done_o");
    chk(tag, rvalid, e_rv, "rvalid_o");
    chk(tag, rdata, e_rd, "rdata_o");
    wdata = m_busy ? wpat[m_cnt] : 1'b0;
  endtask

  task automatic run(bit [1:0] o, int ln, logic [K-1:0] pat);
    wpat = pat;
    start = 1'b1; addr = AW'(ln); op = o;
    cyc();
    start = 1'b0;
    while (m_busy) cyc();
    cyc();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    cyc(); cyc();
    rst_n = 1'b1;
    cyc(); cyc();
    run(2'b00, 3, '0);                 // R1 zero contents
    tag = "R5";
    run(2'b01, 2, 16'hA5C3);
    run(2'b01, 5, 16'h0F1E);
    run(2'b01, 0, 16'hFFFF);
    run(2'b00, 2, '0);                 // R5 order of readback
    run(2'b00, 5, '0);
    tag = "R4";
    run(2'b00, 0, '0);
    run(2'b00, 2, '0);                 // R4 unchanged by previous read
    tag = "R8";
    run(2'b00, 3, '0);                 // R8 untouched neighbour
    run(2'b00, 1, '0);
    tag = "R6";
    run(2'b10, 5, '0);
    run(2'b00, 5, '0);
    tag = "R9";
    run(2'b11, 2, '0);
    run(2'b00, 2, '0);
    // R7: stray strobe and address/op changes mid-operation
    tag = "R7";
    wpat = 16'h3C96;
    start = 1'b1; addr = 3'd1; op = 2'b01;
    cyc();
    start = 1'b0;
    for (int i = 0; i < 6; i++) cyc();
    start = 1'b1; addr = 3'd6; op = 2'b01;
    cyc();
    start = 1'b0; op = 2'b00; addr = 3'd4;
    while (m_busy) cyc();
    cyc();
    run(2'b00, 6, '0);
    run(2'b00, 1, '0);
    run(2'b00, 4, '0);
    // R10: start coincident with done
    tag = "R10";
    wpat = 16'h8001;
    start = 1'b1; addr = 3'd7; op = 2'b01;
    cyc();
    start = 1'b0;
    while (!m_done) cyc();
    start = 1'b1; addr = 3'd7; op = 2'b00;
    cyc();
    start = 1'b0;
    while (m_busy) cyc();
    cyc(); cyc();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule